// File: doc/BRIEF.md
# Receive Frame Status Tracker

This block sits between a packet deframer for an infrared receive path and the host. The deframer hands over one byte per beat. Each beat carries side tags: frame end, abort, encoding error and missing closing flag. The block stores each byte in a 16-entry receive queue together with three tags of its own: last byte, length overflow and physical-layer error. A frame's status therefore travels with its final byte. The frame-end, length and physical-layer flags are not raised when a condition is detected. They are raised when the tagged final byte first becomes the queue head. The host then reads them, and the read clears them.

A write-side state machine counts the bytes of each frame against a programmable maximum length. It has three states: `S_IDLE` (no frame open, counter at zero), `S_RECV` (frame open, counting) and `S_DROP` (frame has overflowed, bytes discarded). The transitions are:
- `S_IDLE`/`S_RECV` to `S_RECV` on an ordinary byte.
- `S_IDLE`/`S_RECV` to `S_IDLE` on a terminating byte (end, abort or missing-end tag).
- `S_IDLE`/`S_RECV` to `S_DROP` when a byte takes the count past the maximum.
- `S_DROP` to `S_IDLE` on the terminating byte.

A mode input chooses which conditions count as a physical-layer error. With `mode_fast`=0 (medium rate) an abort counts. With `mode_fast`=1 (fast rate) an encoding error or a frame closed by the missing-end tag counts.

Top module: `rx_frame_status`

## Requirements
- R1: After reset `rx_empty`=1, `in_ready`=1 and all three status flags are 0.
- R2: The queue returns bytes in arrival order with `head_data`/`head_last` valid whenever `rx_empty`=0. It holds 16 entries; with 16 stored `in_ready`=0, and a beat offered then is dropped.
- R3: `st_frame_end` stays 0 while a frame's final byte is not yet at the head. It goes to 1 on the clock edge after that byte first becomes the head.
- R4: Let a frame have L bytes against maximum M. If L ≤ M, all L bytes are stored and only the last has `head_last`=1. If L > M, exactly M+1 bytes are stored, the (M+1)th is marked last, the rest of the frame is discarded, and `st_max_len` is raised with that byte's frame end.
- R5: With `mode_fast`=0, `st_phy_err` is raised at frame end when a stored byte of the frame carried the abort tag; encoding-error and missing-end tags do not raise it.
- R6: With `mode_fast`=1, `st_phy_err` is raised at frame end when a stored byte carried the encoding-error tag or the frame was closed by a stored missing-end beat; an abort does not raise it.
- R7: A beat with any of end, abort or missing-end set closes the frame. Tags on discarded beats have no effect.
- R8: A cycle with `stat_rd`=1 returns the flags and clears them at that clock edge. If a flag is set in the same cycle, the set wins and the flag reads 1 afterwards.
- R9: The byte counter restarts at zero after every closing or overflowing byte, so each frame is measured from its own first byte.
- R10: `pop` while `rx_empty`=1 has no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fast | input | 1 | 0: abort is the error; 1: encoding error or missing end is the error |
| max_len | input | 8 | Largest allowed frame length in bytes |
| in_valid | input | 1 | Deframer beat present |
| in_ready | output | 1 | Queue has space; a beat is taken when valid and ready |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | Beat closes the frame normally |
| in_abort | input | 1 | Beat closes the frame with an abort |
| in_encerr | input | 1 | Encoding error seen on this beat |
| in_noend | input | 1 | Beat closes a frame that lacked its end flag |
| pop | input | 1 | Remove the head entry |
| rx_empty | output | 1 | Queue is empty |
| head_data | output | 8 | Byte at the head |
| head_last | output | 1 | Head byte is the final stored byte of its frame |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| st_frame_end | output | 1 | Frame-end flag |
| st_max_len | output | 1 | Length-overflow flag |
| st_phy_err | output | 1 | Physical-layer error flag |

## Verification
A beat taken at one edge is visible at the head after that edge if the queue was empty. A pop at an edge presents the next byte after that edge. The status flags follow one edge after a final byte becomes the head, and a read clears them at the edge that ends the read cycle. The bench drives on falling edges. It samples the head and checks that `st_frame_end` is still 0 at the falling edge right after a final byte arrives, then samples the flags one rising edge later. The set-and-read collision is placed in exactly the cycle in which the head event is pending.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              last;
        logic              ovf;
        logic              phy;
    } rfs_entry_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RECV = 2'd1,
        S_DROP = 2'd2
    } rfs_state_e;
endpackage

// File: rtl/rfs_framer.sv
module rfs_framer
    import rfs_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_fast,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              in_valid,
    input  logic              space_ok,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eof,
    input  logic              in_abort,
    input  logic              in_encerr,
    input  logic              in_noend,
    output logic              wr_en,
    output rfs_entry_t        wr_ent
);
    localparam int CNT_W = LEN_W + 1;

    rfs_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic             phy_acc;
    logic             accept, closing, err_now, over;

    assign accept  = in_valid && space_ok;
    assign closing = in_eof || in_abort || in_noend;
    assign err_now = mode_fast ? (in_encerr || in_noend) : in_abort;
    assign cnt_nx  = cnt + 1'b1;
    assign over    = cnt_nx > {1'b0, max_len};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            phy_acc <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept && state != S_DROP) begin
                if (closing || over) begin
                    cnt     <= '0;
                    phy_acc <= 1'b0;
                end else begin
                    cnt     <= cnt_nx;
                    phy_acc <= phy_acc || err_now;
                end
            end
        end
    end

    always_comb begin
        state_nx    = state;
        wr_en       = 1'b0;
        wr_ent      = '0;
        wr_ent.data = in_data;
        unique case (state)
            S_IDLE, S_RECV: begin
                if (accept) begin
                    wr_en       = 1'b1;
                    wr_ent.last = closing || over;
                    wr_ent.ovf  = over;
                    wr_ent.phy  = (closing || over) && (phy_acc || err_now);
                    if (closing)   state_nx = S_IDLE;
                    else if (over) state_nx = S_DROP;
                    else           state_nx = S_RECV;
                end
            end
            S_DROP: begin
                if (accept && closing) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // R4
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_DROP |-> !wr_en);

    // R4
    ovf_marks_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ent.ovf) |-> wr_ent.last);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_RECV) |-> (cnt == '0));
endmodule

// File: rtl/rfs_fifo.sv
module rfs_fifo
    import rfs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  rfs_entry_t wr_ent,
    input  logic       rd_en,
    output rfs_entry_t rd_ent,
    output logic       empty,
    output logic       full
);
    localparam int              AW       = $clog2(DEPTH);
    localparam logic [AW-1:0]   LAST_PTR = AW'(DEPTH - 1);
    localparam logic [AW:0]     FULL_CNT = (AW + 1)'(DEPTH);

    rfs_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_wr, do_rd;

    assign empty  = (count == '0);
    assign full   = (count == FULL_CNT);
    assign do_wr  = wr_en && !full;
    assign do_rd  = rd_en && !empty;
    assign rd_ent = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> empty);
endmodule

// File: rtl/rfs_flags.sv
module rfs_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic head_last,
    input  logic head_ovf,
    input  logic head_phy,
    input  logic pop,
    input  logic stat_rd,
    output logic fe_q,
    output logic len_q,
    output logic phy_q
);
    logic head_seen;
    logic evt;

    assign evt = head_valid && !head_seen && head_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_seen <= 1'b0;
            fe_q      <= 1'b0;
            len_q     <= 1'b0;
            phy_q     <= 1'b0;
        end else begin
            if (pop && head_valid) head_seen <= 1'b0;
            else if (head_valid)   head_seen <= 1'b1;

            if (evt)          fe_q <= 1'b1;
            else if (stat_rd) fe_q <= 1'b0;

            if (evt && head_ovf) len_q <= 1'b1;
            else if (stat_rd)    len_q <= 1'b0;

            if (evt && head_phy) phy_q <= 1'b1;
            else if (stat_rd)    phy_q <= 1'b0;
        end
    end

    // R3
    fe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_q) |-> $past(head_valid && head_last));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> fe_q);

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !evt) |=> (!fe_q && !len_q && !phy_q));
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
    import rfs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_fast,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eof,
    input  logic              in_abort,
    input  logic              in_encerr,
    input  logic              in_noend,
    input  logic              pop,
    output logic              rx_empty,
    output logic [DATA_W-1:0] head_data,
    output logic              head_last,
    input  logic              stat_rd,
    output logic              st_frame_end,
    output logic              st_max_len,
    output logic              st_phy_err
);
    logic       wr_en, full, empty;
    rfs_entry_t wr_ent, rd_ent;

    assign in_ready  = !full;
    assign rx_empty  = empty;
    assign head_data = rd_ent.data;
    assign head_last = rd_ent.last;

    rfs_framer #(.LEN_W(LEN_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_fast (mode_fast),
        .max_len   (max_len),
        .in_valid  (in_valid),
        .space_ok  (!full),
        .in_data   (in_data),
        .in_eof    (in_eof),
        .in_abort  (in_abort),
        .in_encerr (in_encerr),
        .in_noend  (in_noend),
        .wr_en     (wr_en),
        .wr_ent    (wr_ent)
    );

    rfs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_ent (wr_ent),
        .rd_en  (pop),
        .rd_ent (rd_ent),
        .empty  (empty),
        .full   (full)
    );

    rfs_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!empty),
        .head_last  (rd_ent.last),
        .head_ovf   (rd_ent.ovf),
        .head_phy   (rd_ent.phy),
        .pop        (pop),
        .stat_rd    (stat_rd),
        .fe_q       (st_frame_end),
        .len_q      (st_max_len),
        .phy_q      (st_phy_err)
    );
endmodule

// File: tb/tb_rx_frame_status.sv
`timescale 1ns/1ps
module tb_rx_frame_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_fast = 1'b0;
    logic [7:0] max_len = 8'd4;
    logic       in_valid = 1'b0, in_eof = 1'b0, in_abort = 1'b0;
    logic       in_encerr = 1'b0, in_noend = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       pop = 1'b0, stat_rd = 1'b0;
    logic       in_ready, rx_empty, head_last;
    logic [7:0] head_data;
    logic       st_frame_end, st_max_len, st_phy_err;
    int         n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    rx_frame_status dut (
        .clk(clk), .rst_n(rst_n), .mode_fast(mode_fast), .max_len(max_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_eof(in_eof), .in_abort(in_abort), .in_encerr(in_encerr),
        .in_noend(in_noend), .pop(pop), .rx_empty(rx_empty),
        .head_data(head_data), .head_last(head_last), .stat_rd(stat_rd),
        .st_frame_end(st_frame_end), .st_max_len(st_max_len),
        .st_phy_err(st_phy_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit eof, input bit ab,
                        input bit enc, input bit ne);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_eof = eof; in_abort = ab;
        in_encerr = enc; in_noend = ne;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0; in_abort = 1'b0;
        in_encerr = 1'b0; in_noend = 1'b0;
    endtask

    task automatic pop1();
        pop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pop = 1'b0;
    endtask

    // Called at a falling edge right after the last beat was taken.
    task automatic drain(input int base, input int stored, input bit e_ovf,
                         input bit e_phy, input string phy_req);
        for (int k = 0; k < stored; k++) begin
            chk("R2 head present", rx_empty, 0);
            chk("R2 head data order", head_data, (base + k) % 256);
            chk("R4 last marker", head_last, (k == stored - 1) ? 1 : 0);
            chk("R3 frame end held back", st_frame_end, 0);
            if (k == stored - 1) begin
                @(posedge clk);
                @(negedge clk);
                chk("R3 frame end raised", st_frame_end, 1);
                chk("R4 max length flag", st_max_len, e_ovf);
                chk(phy_req, st_phy_err, e_phy);
                stat_rd = 1'b1;
                @(posedge clk);
                @(negedge clk);
                stat_rd = 1'b0;
                chk("R8 read clears frame end", st_frame_end, 0);
                chk("R8 read clears max length", st_max_len, 0);
                chk("R8 read clears phy error", st_phy_err, 0);
            end
            pop1();
        end
        chk("R2 empty after frame", rx_empty, 1);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int frame_no;
        frame_no = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 empty at reset", rx_empty, 1);
        chk("R1 ready at reset", in_ready, 1);
        chk("R1 frame end at reset", st_frame_end, 0);
        chk("R1 max length at reset", st_max_len, 0);
        chk("R1 phy error at reset", st_phy_err, 0);

        // R10: pop on empty queue, then a byte must come out intact
        pop1();
        chk("R10 still empty", rx_empty, 1);
        send(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0);
        drain(8'h3C, 1, 1'b0, 1'b0, "R10 phy after empty pop");

        // R2: fill all 16 entries, offer one more beat while full
        max_len = 8'd255;
        for (int i = 0; i < 16; i++)
            send(8'(8'hA0 + i), (i == 15), 1'b0, 1'b0, 1'b0);
        chk("R2 not ready when 16 held", in_ready, 0);
        send(8'h55, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2 still not ready", in_ready, 0);
        drain(8'hA0, 16, 1'b0, 1'b0, "R2 dropped beat left no phy error");

        // R8: read collides with the set event
        send(8'h77, 1'b1, 1'b0, 1'b0, 1'b0);
        stat_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R8 set wins over read", st_frame_end, 1);
        stat_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R8 later read clears", st_frame_end, 0);
        pop1();
        chk("R8 queue empty", rx_empty, 1);

        // Sweep: R4 R5 R6 R7 R9 over mode, max, length, close kind, error spot
        for (int m = 0; m < 2; m++)
            for (int mx = 1; mx <= 4; mx++)
                for (int len = 1; len <= 6; len++)
                    for (int tt = 0; tt < 3; tt++)
                        for (int ep = 0; ep < 3; ep++) begin
                            int  base, stored;
                            bit  e_ovf, e_phy, enc_kept;
                            string req;
                            base = (frame_no * 8) % 256;
                            frame_no++;
                            mode_fast = m[0];
                            max_len = 8'(mx);
                            for (int i = 0; i < len; i++) begin
                                bit cl;
                                bit enc;
                                cl = (i == len - 1);
                                enc = (ep == 1 && i == 0) || (ep == 2 && i == len - 1);
                                send(8'((base + i) % 256), cl && tt == 0,
                                     cl && tt == 1, enc, cl && tt == 2);
                            end
                            stored = (len <= mx) ? len : mx + 1;
                            e_ovf  = (len > mx);
                            enc_kept = (ep == 1) || (ep == 2 && len == stored);
                            if (m == 1)
                                e_phy = enc_kept || (tt == 2 && len == stored);
                            else
                                e_phy = (tt == 1 && len == stored);
                            req = (m == 1) ? "R6 fast-mode phy error (R7 R9)"
                                           : "R5 medium-mode phy error (R7 R9)";
                            drain(base, stored, e_ovf, e_phy, req);
                        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule